// File: doc/BRIEF.md
# Processor Control Register Slave

This block is a memory-mapped slave on an AXI4-Lite bus. It gives a processor four 32-bit register words that connect to a piece of user logic in the same clock domain. The processor can write a control word and a configuration word. It can read back those two words, a status word and a result word. The status and result words are driven by the user logic and cannot be written from the bus.

A write is taken only when the write address and the write data are both valid in the same cycle. Each byte lane is written only if its strobe is set. Every response is OKAY. The control word has two command bits, start and clear. Writing a 1 to either of them produces a single-cycle pulse toward the user logic, and both bits always read back as 0. At most one transaction per direction is in flight at any time.

Top module: `ctrl_reg_slave`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, awready, wready, bvalid, arready, rvalid, start_pulse and clear_pulse are 0. Reset also clears ctrl_word and cfg_word to 0.
- R2: awready and wready are high only in a cycle where awvalid and wvalid are both high. Either valid alone causes no handshake and no response.
- R3: In the cycle after a write is accepted, bvalid is 1 and bresp is 2'b00. bvalid stays 1 until a cycle in which bready is high.
- R4: After a read address handshake, rvalid is 1 with rresp 2'b00. rvalid and rdata hold steady until a cycle in which rready is high.
- R5: The bytes of wdata and wstrb are numbered from the least significant end. During a write, wstrb bit b enables data byte b (bits 8b+7..8b). A lane whose strobe is 0 keeps its old value, and the command bits react only when wstrb[0] is 1.
- R6: The register word index is address bits [ADDR_W-1:2]. Index 0 is control, index 1 is status (bit0 done, bit1 busy, other bits 0), index 2 is configuration (shown on cfg_word), and index 3 is result (result_in).
- R7: Writes to index 1, index 3 and indices 4 and above change nothing. Reads from indices 4 and above return 0. Both still complete with an OKAY response.
- R8: If an accepted write to index 0 has wdata[0]=1, start_pulse is high for exactly the cycle after the write is accepted. Control bit 0 reads back as 0.
- R9: If an accepted write to index 0 has wdata[1]=1, clear_pulse is high for exactly the cycle after the write is accepted. Control bit 1 reads back as 0. Control bits 31..2 are stored and appear on ctrl_word.
- R10: No new write is accepted while bvalid is 1, and no new read is accepted while rvalid is 1.
- R11: While rst_n is low, no read or write is accepted, even if all valids are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| start_pulse | output | 1 | One-cycle start command |
| clear_pulse | output | 1 | One-cycle clear command |
| ctrl_word | output | 32 | Stored control word, command bits shown as 0 |
| cfg_word | output | 32 | Configuration word |
| status_done | input | 1 | Done flag from user logic |
| status_busy | input | 1 | Busy flag from user logic |
| result_in | input | 32 | Result from user logic |

## Verification
The hardest case to reach is a second valid request that arrives while the earlier response has not yet been taken. A bus master that drains responses promptly never creates it. To reach it, the bench holds bready (or rready) low for several cycles after an accepted transaction and keeps a second write (or read) with different data and address on the bus. It then checks three things: the ready stays low, the registered data and the pending rdata do not change, and the second request is taken only after the response handshake has finished.

// File: rtl/crs_pkg.sv
// Package crs_pkg
// Shared constants for the control register slave: bus width, byte lanes,
// response code and the word index of every register.
package crs_pkg;
    localparam int          DATA_W    = 32;
    localparam int          STRB_W    = DATA_W / 8;
    localparam int          LSB       = $clog2(STRB_W);
    localparam logic [1:0]  RESP_OKAY = 2'b00;
    localparam int          IDX_CTRL  = 0;
    localparam int          IDX_STAT  = 1;
    localparam int          IDX_CFG   = 2;
    localparam int          IDX_RSLT  = 3;
    localparam int          CMD_START = 0;
    localparam int          CMD_CLEAR = 1;
endpackage

// File: rtl/crs_wr_chan.sv
// Module crs_wr_chan
// Write-side handshake. Address and data are accepted together in one cycle,
// and only while no response is still waiting. It then holds an OKAY response
// until the master takes it.
// Assumes: synchronous active-low reset; word-aligned addresses.
module crs_wr_chan
    import crs_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int IDX_W = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    input  logic              wvalid,
    input  logic              bready,
    output logic              awready,
    output logic              wready,
    output logic              bvalid,
    output logic [1:0]        bresp,
    output logic              wr_fire,
    output logic [IDX_W-1:0]  wr_idx
);
    logic bvalid_q;
    logic unused_wr_lsb;

    // Accept only with both valids present, out of reset, and no response pending.
    assign wr_fire       = rst_n && awvalid && wvalid && !bvalid_q;
    assign awready       = wr_fire;
    assign wready        = wr_fire;
    assign wr_idx        = awaddr[ADDR_W-1:LSB];
    assign unused_wr_lsb = ^awaddr[LSB-1:0];
    assign bvalid        = bvalid_q;
    assign bresp         = RESP_OKAY;

    // Response valid: set on accept, cleared on response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)          bvalid_q <= 1'b0;
        else if (wr_fire)    bvalid_q <= 1'b1;
        else if (bready)     bvalid_q <= 1'b0;
    end

    assert_ready_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        awready |-> (awvalid && wvalid));
    assert_bvalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    assert_no_write_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready);
endmodule

// File: rtl/crs_rd_chan.sv
// Module crs_rd_chan
// Read-side handshake. It takes one read address at a time, captures the
// addressed word in the accept cycle, and holds it with an OKAY response until
// the master takes it.
// Assumes: synchronous active-low reset; the read word is combinational in rd_idx.
module crs_rd_chan
    import crs_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int IDX_W = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] rd_word,
    output logic              arready,
    output logic              rvalid,
    output logic [1:0]        rresp,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  rd_idx
);
    logic              rvalid_q;
    logic              rd_fire;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_rd_lsb;

    // Accept a read address only out of reset and with no data pending.
    assign rd_fire       = rst_n && arvalid && !rvalid_q;
    assign arready       = rd_fire;
    assign rd_idx        = araddr[ADDR_W-1:LSB];
    assign unused_rd_lsb = ^araddr[LSB-1:0];
    assign rvalid        = rvalid_q;
    assign rdata         = rdata_q;
    assign rresp         = RESP_OKAY;

    // Data valid and captured word: loaded on accept, held until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assert_rvalid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);
    assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> $stable(rdata));
    assert_no_read_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);
endmodule

// File: rtl/crs_regfile.sv
// Module crs_regfile
// Register storage and decode: control and configuration words with byte-lane
// writes, command pulses from the two low control bits, and the read
// multiplexer, which includes the status and result inputs.
// Assumes: wr_fire is a one-cycle accept strobe; synchronous active-low reset.
module crs_regfile
    import crs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              status_done,
    input  logic              status_busy,
    input  logic [DATA_W-1:0] result_in,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] cfg_word,
    output logic              start_pulse,
    output logic              clear_pulse
);
    localparam logic [DATA_W-1:0] CMD_MASK = DATA_W'(3);

    logic [DATA_W-1:0] ctrl_q, cfg_q, ctrl_nxt, cfg_nxt;
    logic              hit_ctrl, hit_cfg;
    logic              start_q, clear_q;

    assign hit_ctrl = wr_fire && (wr_idx == IDX_W'(IDX_CTRL));
    assign hit_cfg  = wr_fire && (wr_idx == IDX_W'(IDX_CFG));

    // Per-lane next value: a lane follows wdata only when its strobe is set.
    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
        assign ctrl_nxt[b*8 +: 8] = (hit_ctrl && wstrb[b]) ? wdata[b*8 +: 8] : ctrl_q[b*8 +: 8];
        assign cfg_nxt[b*8 +: 8]  = (hit_cfg  && wstrb[b]) ? wdata[b*8 +: 8] : cfg_q[b*8 +: 8];
    end

    // Storage: command bits are never kept, so they always read as 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            ctrl_q <= ctrl_nxt & ~CMD_MASK;
            cfg_q  <= cfg_nxt;
        end
    end

    // Command pulses: one cycle after an accepted control write with the bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            start_q <= hit_ctrl && wstrb[0] && wdata[CMD_START];
            clear_q <= hit_ctrl && wstrb[0] && wdata[CMD_CLEAR];
        end
    end

    // Read multiplexer: unmapped indices return 0.
    always_comb begin
        rd_word = '0;
        case (rd_idx)
            IDX_W'(IDX_CTRL): rd_word = ctrl_q;
            IDX_W'(IDX_STAT): rd_word = {{(DATA_W-2){1'b0}}, status_busy, status_done};
            IDX_W'(IDX_CFG):  rd_word = cfg_q;
            IDX_W'(IDX_RSLT): rd_word = result_in;
            default:          rd_word = '0;
        endcase
    end

    assign ctrl_word   = ctrl_q;
    assign cfg_word    = cfg_q;
    assign start_pulse = start_q;
    assign clear_pulse = clear_q;

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_clear_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> !clear_pulse);
    assert_cfg_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(cfg_word));
    assert_ctrl_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(ctrl_word));
endmodule

// File: rtl/ctrl_reg_slave.sv
// Module ctrl_reg_slave
// AXI4-Lite slave with four 32-bit register words for one block of user logic:
// control (with start and clear commands), status (read-only), configuration,
// and result (read-only).
// Assumes: one clock domain; synchronous active-low reset; word-aligned access.
module ctrl_reg_slave
    import crs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              start_pulse,
    output logic              clear_pulse,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       cfg_word,
    input  logic              status_done,
    input  logic              status_busy,
    input  logic [31:0]       result_in
);
    localparam int IDX_W = ADDR_W - LSB;

    logic              wr_fire;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_word;

    crs_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid),
        .wvalid(wvalid), .bready(bready), .awready(awready), .wready(wready),
        .bvalid(bvalid), .bresp(bresp), .wr_fire(wr_fire), .wr_idx(wr_idx)
    );

    crs_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .araddr(araddr), .arvalid(arvalid),
        .rready(rready), .rd_word(rd_word), .arready(arready), .rvalid(rvalid),
        .rresp(rresp), .rdata(rdata), .rd_idx(rd_idx)
    );

    crs_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx),
        .wdata(wdata), .wstrb(wstrb), .rd_idx(rd_idx),
        .status_done(status_done), .status_busy(status_busy),
        .result_in(result_in), .rd_word(rd_word), .ctrl_word(ctrl_word),
        .cfg_word(cfg_word), .start_pulse(start_pulse), .clear_pulse(clear_pulse)
    );

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!bvalid && !rvalid && !start_pulse && !clear_pulse));
endmodule

// File: tb/tb_ctrl_reg_slave.sv
module tb_ctrl_reg_slave;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic          awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0]   wdata = '0, result_in = '0;
    logic [3:0]    wstrb = '0;
    logic          status_done = 0, status_busy = 0;
    logic          awready, wready, bvalid, arready, rvalid, start_pulse, clear_pulse;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata, ctrl_word, cfg_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic got_start, got_clear;

    always #2.5 clk = ~clk;

    ctrl_reg_slave #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .start_pulse(start_pulse), .clear_pulse(clear_pulse),
        .ctrl_word(ctrl_word), .cfg_word(cfg_word),
        .status_done(status_done), .status_busy(status_busy), .result_in(result_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Full write with response back-pressure of 'hold' cycles; records pulses.
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s, input int hold);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 0;
        #0.5;
        check(awready && wready, "R2 ready pair on joint valid", {awready, wready}, 2'b11);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check(bvalid && bresp == 2'b00, "R3 bvalid with OKAY", {bvalid, bresp}, 3'b100);
        got_start = start_pulse; got_clear = clear_pulse;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(bvalid, "R3 bvalid held without bready", bvalid, 1);
            check(!start_pulse && !clear_pulse, "R8 R9 pulse one cycle", {start_pulse, clear_pulse}, 0);
        end
        bready = 1;
        @(negedge clk);
        bready = 0;
        check(!bvalid, "R3 bvalid drops after bready", bvalid, 0);
        if (hold == 0)
            check(!start_pulse && !clear_pulse, "R8 R9 pulse one cycle", {start_pulse, clear_pulse}, 0);
    endtask

    // Full read with data back-pressure of 'hold' cycles; compares data.
    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] exp, input int hold, input string req);
        logic [31:0] first;
        @(negedge clk);
        araddr = a; arvalid = 1; rready = 0;
        #0.5;
        check(arready, "R4 arready on arvalid", arready, 1);
        @(negedge clk);
        arvalid = 0;
        check(rvalid && rresp == 2'b00, "R4 rvalid with OKAY", {rvalid, rresp}, 3'b100);
        check(rdata == exp, req, rdata, exp);
        first = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rvalid && rdata == first, "R4 rvalid and rdata held", rdata, first);
        end
        rready = 1;
        @(negedge clk);
        rready = 0;
        check(!rvalid, "R4 rvalid drops after rready", rvalid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        awvalid = 1; wvalid = 1; arvalid = 1; awaddr = 6'h08; araddr = 6'h08;
        wdata = 32'hFFFF_FFFF; wstrb = 4'hF;
        #0.5;
        check(!awready && !wready && !arready, "R11 no accept in reset", {awready, wready, arready}, 0);
        @(negedge clk);
        check(!bvalid && !rvalid && !start_pulse && !clear_pulse, "R1 outputs idle in reset",
              {bvalid, rvalid, start_pulse, clear_pulse}, 0);
        awvalid = 0; wvalid = 0; arvalid = 0;
        rst_n = 1;
        @(negedge clk);
        check(cfg_word == 0 && ctrl_word == 0, "R1 registers cleared", cfg_word | ctrl_word, 0);
        check(!bvalid && !rvalid, "R1 R11 nothing accepted during reset", {bvalid, rvalid}, 0);
    endtask

    task automatic t_single_valid();
        @(negedge clk);
        awaddr = 6'h08; awvalid = 1; wvalid = 0;
        #0.5;
        check(!awready && !wready, "R2 awvalid alone", {awready, wready}, 0);
        @(negedge clk);
        check(!bvalid, "R2 no response on awvalid alone", bvalid, 0);
        awvalid = 0; wvalid = 1; wdata = 32'h5555_5555; wstrb = 4'hF;
        #0.5;
        check(!awready && !wready, "R2 wvalid alone", {awready, wready}, 0);
        @(negedge clk);
        wvalid = 0;
        check(!bvalid && cfg_word == 0, "R2 no write on wvalid alone", cfg_word, 0);
    endtask

    task automatic t_cfg_strobes();
        do_write(6'h08, 32'h1234_5678, 4'hF, 3);
        check(cfg_word == 32'h1234_5678, "R6 cfg_word follows write", cfg_word, 32'h1234_5678);
        do_read(6'h08, 32'h1234_5678, 2, "R6 read configuration");
        do_write(6'h08, 32'hAABB_CCDD, 4'b0100, 0);
        check(cfg_word == 32'h12BB_5678, "R5 single lane write", cfg_word, 32'h12BB_5678);
        do_write(6'h08, 32'hEEFF_0011, 4'b1001, 1);
        check(cfg_word == 32'hEEBB_5611, "R5 two lane write", cfg_word, 32'hEEBB_5611);
    endtask

    task automatic t_readonly();
        status_done = 1; status_busy = 0; result_in = 32'hCAFE_0042;
        do_read(6'h04, 32'h1, 0, "R6 status done bit");
        status_done = 0; status_busy = 1;
        do_read(6'h04, 32'h2, 0, "R6 status busy bit");
        do_write(6'h04, 32'hFFFF_FFFF, 4'hF, 0);
        do_read(6'h04, 32'h2, 0, "R7 status ignores writes");
        do_write(6'h0C, 32'h0, 4'hF, 0);
        do_read(6'h0C, 32'hCAFE_0042, 0, "R7 result ignores writes");
        do_write(6'h14, 32'h0BAD_0BAD, 4'hF, 0);
        check(cfg_word == 32'hEEBB_5611 && ctrl_word == 0, "R7 unmapped write ignored", cfg_word, 32'hEEBB_5611);
        do_read(6'h14, 32'h0, 0, "R7 unmapped read is zero");
        do_read(6'h3C, 32'h0, 0, "R7 top index read is zero");
    endtask

    task automatic t_commands();
        do_write(6'h00, 32'h0000_1201, 4'hF, 0);
        check(got_start && !got_clear, "R8 start pulse only", {got_start, got_clear}, 2'b10);
        check(ctrl_word == 32'h0000_1200, "R9 upper control bits kept", ctrl_word, 32'h0000_1200);
        do_read(6'h00, 32'h0000_1200, 0, "R8 start bit reads zero");
        do_write(6'h00, 32'h0000_1202, 4'h1, 2);
        check(!got_start && got_clear, "R9 clear pulse only", {got_start, got_clear}, 2'b01);
        do_read(6'h00, 32'h0000_1200, 0, "R9 clear bit reads zero");
        do_write(6'h00, 32'h0000_0003, 4'b1110, 0);
        check(!got_start && !got_clear, "R5 strobe zero blocks commands", {got_start, got_clear}, 0);
        check(ctrl_word == 32'h0000_0000, "R5 upper lanes written", ctrl_word, 0);
    endtask

    task automatic t_pending();
        // A second write waits while the first response is pending.
        @(negedge clk);
        awaddr = 6'h08; wdata = 32'h1111_1111; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
        @(negedge clk);
        wdata = 32'h2222_2222;
        #0.5;
        check(!awready && !wready, "R10 write blocked while bvalid", {awready, wready}, 0);
        @(negedge clk);
        check(cfg_word == 32'h1111_1111, "R10 second write not taken", cfg_word, 32'h1111_1111);
        awvalid = 0; wvalid = 0; bready = 1;
        @(negedge clk);
        bready = 0;
        check(!bvalid && cfg_word == 32'h1111_1111, "R10 nothing taken after drain", cfg_word, 32'h1111_1111);
        // A second read waits while the first data is pending.
        @(negedge clk);
        araddr = 6'h08; arvalid = 1; rready = 0;
        @(negedge clk);
        araddr = 6'h0C;
        #0.5;
        check(!arready, "R10 read blocked while rvalid", arready, 0);
        @(negedge clk);
        check(rvalid && rdata == 32'h1111_1111, "R10 pending rdata unchanged", rdata, 32'h1111_1111);
        rready = 1;
        @(negedge clk);
        rready = 0;
        check(!rvalid, "R10 first read drained", rvalid, 0);
        #0.5;
        check(arready, "R10 second read taken after drain", arready, 1);
        @(negedge clk);
        arvalid = 0;
        check(rvalid && rdata == 32'hCAFE_0042, "R10 second read data", rdata, 32'hCAFE_0042);
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    initial begin
        t_reset();
        t_single_valid();
        t_cfg_strobes();
        t_readonly();
        t_commands();
        t_pending();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule